// File: doc/BRIEF.md
# Pseudo-Random Loopback Self-Test Engine

This block exercises a nibble-wide data path end to end. A generator sends a pseudo-random nibble stream out on a valid/ready transmit port. A loopback path outside the block returns that stream to a receive port. There, a checker with its own shift register predicts each returned nibble and compares it with what arrived. A latched pass flag and a saturating 8-bit error count are the verdict.

Software drives four plain control pins. A write strobe `ctl_wr` carries a run/stop value, and with it two configuration bits that are captured on a start write. `ctl_long` selects the sequence: 0 gives a 9-bit register with polynomial x^9+x^5+1, and 1 gives a 15-bit register with x^15+x^14+1. `ctl_cont` selects the transmit pattern: 1 sends an unbroken stream, and 0 sends fixed-length bursts separated by idle gaps.

The generator is seeded from a nonzero parameter on every control write. The checker does not need to know the loop latency. It first fills its register from the incoming bits and only then starts comparing. It never back-pressures: `rx_ready` equals `running`. On the transmit port, the consumer may hold `tx_ready` low for any number of cycles. While it does, the offered nibble stays put and the sequence does not advance.

Top module: `prbs_selftest`

## Requirements
- R1: After reset, `pass`=0, `err_count`=0, `running`=0, `tx_valid`=0 and `rx_ready`=0.
- R2: With `ctl_long`=0, the transmitted bit stream obeys b[n] = b[n-9] XOR b[n-5]. Bit 3 of each nibble is the oldest bit. The nibble sequence repeats every 511 nibbles.
- R3: With `ctl_long`=1, the transmitted bit stream obeys b[n] = b[n-15] XOR b[n-14], with the same bit order as R2.
- R4: While running in continuous mode, `tx_valid` is high in every cycle. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. The sequence advances only on a handshake.
- R5: With `ctl_cont`=0, the generator sends PKT_NIBBLES handshaken nibbles and then keeps `tx_valid` low for GAP_CYCLES cycles, repeating this pattern.
- R6: The checker loads its register from the first 3 accepted nibbles (9-bit mode) or the first 4 (15-bit mode) without comparing them. Any fixed loop latency therefore causes no errors.
- R7: `pass` rises one cycle after the first compared nibble that matches, provided no miscompare has occurred since the last control write.
- R8: A compared nibble with any bit wrong drives `pass` to 0 in the next cycle and adds exactly 1 to `err_count`. `pass` then stays 0 until the next control write.
- R9: `err_count` saturates at 255.
- R10: A write with `ctl_run`=1 restarts the test: it zeroes `err_count` and `pass`, reseeds the generator and resynchronises the checker. A write with `ctl_run`=0 stops the test: it zeroes `pass` and holds `err_count`. While stopped, receive data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_run | input | 1 | Run (1) or stop (0) value of the write |
| ctl_long | input | 1 | Sequence select, captured on a start write |
| ctl_cont | input | 1 | Continuous (1) or burst (0) transmit, captured on a start write |
| tx_valid | output | 1 | Transmit nibble offered |
| tx_ready | input | 1 | Transmit consumer accepts |
| tx_data | output | 4 | Transmit nibble |
| rx_valid | input | 1 | Looped-back nibble present |
| rx_ready | output | 1 | Checker accepts (equals running) |
| rx_data | input | 4 | Looped-back nibble |
| running | output | 1 | Test in progress |
| pass | output | 1 | Latched pass (1) / fail (0) status |
| err_count | output | 8 | Saturating miscompare count |

## Verification
Control writes act at the clock edge that samples them. `running`, `err_count` and `pass` therefore already show a write's effect two nanoseconds after that edge, and the bench checks them there. `tx_data` is decoded from the generator register, so each handshake exposes the next nibble at the following edge. The bench records nibbles at falling edges, only when valid and ready are both high. Miscompare results appear one edge after the receive handshake, plus the bench's own three-stage loop delay. The bench therefore lets several tens of cycles pass before it reads `pass` or `err_count`. It flushes its loop on every control write, so stale nibbles never reach a resynchronising checker.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int NIB_W     = 4;
  localparam int LFSR_W    = 15;
  localparam int SHORT_LEN = 9;
  localparam int LONG_LEN  = 15;
  localparam int SYNC_SHORT = (SHORT_LEN + NIB_W - 1) / NIB_W;
  localparam int SYNC_LONG  = (LONG_LEN + NIB_W - 1) / NIB_W;

  typedef struct packed {
    logic [LFSR_W-1:0] st;
    logic [NIB_W-1:0]  nib;
  } lfsr_step_t;

  // Advance the register by one nibble. The predicted bits always come out
  // in nib (oldest in the top bit). When load is set, the register shifts in
  // din instead of its own prediction (self-synchronisation).
  function automatic lfsr_step_t lfsr_step(input logic [LFSR_W-1:0] st_in,
                                           input logic              long_mode,
                                           input logic [NIB_W-1:0]  din,
                                           input logic              load);
    lfsr_step_t r;
    logic [LFSR_W-1:0] s;
    logic fb;
    s = st_in;
    r.nib = '0;
    for (int i = NIB_W - 1; i >= 0; i--) begin
      fb = long_mode ? (s[LONG_LEN-1] ^ s[LONG_LEN-2]) : (s[SHORT_LEN-1] ^ s[4]);
      r.nib[i] = fb;
      s = {s[LFSR_W-2:0], load ? din[i] : fb};
    end
    r.st = s;
    return r;
  endfunction

endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
  import prbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 15'h1ACE,
  parameter int PKT_NIBBLES = 16,
  parameter int GAP_CYCLES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             long_mode,
  input  logic             cont_mode,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [NIB_W-1:0] tx_data
);
  localparam int BCW = $clog2(PKT_NIBBLES + 1);
  localparam int GCW = $clog2(GAP_CYCLES + 2);
  localparam logic [BCW-1:0] BURST_LAST = BCW'(PKT_NIBBLES - 1);
  localparam logic [GCW-1:0] GAP_LAST   = GCW'(GAP_CYCLES > 0 ? GAP_CYCLES - 1 : 0);
  localparam logic HAS_GAP = (GAP_CYCLES > 0);

  logic [LFSR_W-1:0] st;
  logic [BCW-1:0]    burst_cnt;
  logic [GCW-1:0]    gap_cnt;
  logic              in_gap;
  lfsr_step_t        nxt;

  always_comb nxt = lfsr_step(st, long_mode, '0, 1'b0);

  assign tx_valid = run && (cont_mode || !in_gap);
  assign tx_data  = nxt.nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEED;
      burst_cnt <= '0;
      gap_cnt   <= '0;
      in_gap    <= 1'b0;
    end else if (restart) begin
      st        <= SEED;
      burst_cnt <= '0;
      gap_cnt   <= '0;
      in_gap    <= 1'b0;
    end else if (run) begin
      if (tx_valid && tx_ready) begin
        st <= nxt.st;
        if (!cont_mode) begin
          if (burst_cnt == BURST_LAST) begin
            burst_cnt <= '0;
            in_gap    <= HAS_GAP;
          end else begin
            burst_cnt <= burst_cnt + 1'b1;
          end
        end
      end
      if (in_gap) begin
        if (gap_cnt == GAP_LAST) begin
          gap_cnt <= '0;
          in_gap  <= 1'b0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk
  import prbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             long_mode,
  input  logic             rx_valid,
  input  logic [NIB_W-1:0] rx_data,
  output logic             cmp_valid,
  output logic             cmp_err
);
  localparam logic [2:0] NEED_SHORT = 3'(SYNC_SHORT);
  localparam logic [2:0] NEED_LONG  = 3'(SYNC_LONG);

  logic [LFSR_W-1:0] st;
  logic [2:0]        sync_cnt;
  logic              locked;
  logic              accept;
  lfsr_step_t        nxt;

  assign locked = (sync_cnt == (long_mode ? NEED_LONG : NEED_SHORT));
  assign accept = run && rx_valid;

  always_comb nxt = lfsr_step(st, long_mode, rx_data, !locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= '0;
      sync_cnt  <= '0;
      cmp_valid <= 1'b0;
      cmp_err   <= 1'b0;
    end else if (restart) begin
      st        <= '0;
      sync_cnt  <= '0;
      cmp_valid <= 1'b0;
      cmp_err   <= 1'b0;
    end else if (accept) begin
      st        <= nxt.st;
      cmp_valid <= locked;
      cmp_err   <= locked && (nxt.nib != rx_data);
      if (!locked) sync_cnt <= sync_cnt + 1'b1;
    end else begin
      cmp_valid <= 1'b0;
      cmp_err   <= 1'b0;
    end
  end

endmodule

// File: rtl/prbs_status.sv
module prbs_status #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_run,
  input  logic             cmp_valid,
  input  logic             cmp_err,
  output logic             pass,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic fail_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass      <= 1'b0;
      fail_seen <= 1'b0;
      err_count <= '0;
    end else if (ctl_wr) begin
      pass      <= 1'b0;
      fail_seen <= 1'b0;
      if (ctl_run) err_count <= '0;
    end else if (cmp_valid) begin
      if (cmp_err) begin
        pass      <= 1'b0;
        fail_seen <= 1'b1;
        if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
      end else if (!fail_seen) begin
        pass <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/prbs_selftest.sv
module prbs_selftest
  import prbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 15'h1ACE,
  parameter int PKT_NIBBLES = 16,
  parameter int GAP_CYCLES  = 4,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_run,
  input  logic             ctl_long,
  input  logic             ctl_cont,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [3:0]       tx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [3:0]       rx_data,
  output logic             running,
  output logic             pass,
  output logic [CNT_W-1:0] err_count
);
  logic cfg_long;
  logic cfg_cont;
  logic cmp_valid;
  logic cmp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cfg_long <= 1'b0;
      cfg_cont <= 1'b1;
    end else if (ctl_wr) begin
      running <= ctl_run;
      if (ctl_run) begin
        cfg_long <= ctl_long;
        cfg_cont <= ctl_cont;
      end
    end
  end

  assign rx_ready = running;

  prbs_tx_gen #(
    .SEED(SEED), .PKT_NIBBLES(PKT_NIBBLES), .GAP_CYCLES(GAP_CYCLES)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .restart(ctl_wr), .run(running),
    .long_mode(cfg_long), .cont_mode(cfg_cont), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  prbs_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .restart(ctl_wr), .run(running),
    .long_mode(cfg_long), .rx_valid(rx_valid), .rx_data(rx_data),
    .cmp_valid(cmp_valid), .cmp_err(cmp_err)
  );

  prbs_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
    .cmp_valid(cmp_valid), .cmp_err(cmp_err),
    .pass(pass), .err_count(err_count)
  );

endmodule

// File: rtl/prbs_selftest_sva.sv
module prbs_selftest_sva #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             ctl_run,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [3:0]       tx_data,
  input logic             rx_ready,
  input logic             running,
  input logic             pass,
  input logic [CNT_W-1:0] err_count,
  input logic             cmp_valid,
  input logic             cmp_err
);
  // R1 / R10: nothing offered or accepted while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!tx_valid && !rx_ready));

  // R4: stalled nibble is held
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tx_valid && !tx_ready && !ctl_wr) |=> (tx_valid && $stable(tx_data)));

  // R7: pass only rises after a clean compare
  a_r7_pass_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(cmp_valid && !cmp_err && !ctl_wr));

  // R8: a miscompare drops pass
  a_r8_mismatch_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_err && !ctl_wr) |=> !pass);

  // R8 / R9: count moves by at most one without a write
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ((err_count == $past(err_count)) ||
                 ({1'b0, err_count} == {1'b0, $past(err_count)} + 1'b1)));

  // R10: any control write clears pass; a start zeroes the count
  a_r10_write_clears_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !pass);

  a_r10_start_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_run) |=> (err_count == '0));

endmodule

bind prbs_selftest prbs_selftest_sva #(.CNT_W(CNT_W)) i_sva (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .running(running), .pass(pass),
  .err_count(err_count), .cmp_valid(cmp_valid), .cmp_err(cmp_err)
);

// File: tb/test_prbs_selftest.sv
module test_prbs_selftest;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_run = 1'b0, ctl_long = 1'b0, ctl_cont = 1'b1;
  logic tx_valid, tx_ready = 1'b1;
  logic [3:0] tx_data;
  logic rx_valid = 1'b0, rx_ready;
  logic [3:0] rx_data = 4'h0;
  logic running, pass;
  logic [7:0] err_count;

  always #10 clk = ~clk;

  prbs_selftest i_prbs_selftest (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
    .ctl_long(ctl_long), .ctl_cont(ctl_cont), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .running(running),
    .pass(pass), .err_count(err_count)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side loop and monitors
  logic [3:0] rec [0:1023];
  int nrec = 0;
  bit flush = 0, stall_mode = 0, force_rx = 0, cont_meas = 0;
  int corrupt_left = 0;
  int cyc = 0;
  bit dl_v [0:2];
  logic [3:0] dl_d [0:2];
  bit prev_stalled = 0;
  logic [3:0] prev_data;
  int stall_viol = 0, stall_seen = 0, cont_viol = 0;
  bit bm_en = 0, bm_init = 0, bm_first = 0, bm_prev = 0;
  int bm_len = 0, bm_viol = 0, bm_runs = 0;

  always @(negedge clk) begin
    bit hs;
    cyc++;
    if (flush) begin
      for (int i = 0; i < 3; i++) begin dl_v[i] = 0; dl_d[i] = 4'h0; end
      nrec = 0;
      prev_stalled = 0;
      tx_ready = 1'b1;
      rx_valid = 1'b0;
      flush = 0;
    end else begin
      tx_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      if (prev_stalled) begin
        stall_seen++;
        if (!tx_valid || tx_data != prev_data) stall_viol++;
      end
      prev_stalled = tx_valid && !tx_ready;
      prev_data = tx_data;
      hs = tx_valid && tx_ready;
      if (hs && nrec < 1024) begin rec[nrec] = tx_data; nrec++; end
      dl_v[2] = dl_v[1]; dl_d[2] = dl_d[1];
      dl_v[1] = dl_v[0]; dl_d[1] = dl_d[0];
      dl_v[0] = hs; dl_d[0] = tx_data;
      if (hs && corrupt_left > 0) begin dl_d[0] = tx_data ^ 4'h1; corrupt_left--; end
      if (force_rx) begin rx_valid = 1'b1; rx_data = cyc[3:0]; end
      else begin rx_valid = dl_v[2]; rx_data = dl_d[2]; end
      if (cont_meas && running && !tx_valid) cont_viol++;
      if (bm_en) begin
        if (bm_init) begin
          bm_init = 0; bm_first = 1; bm_prev = tx_valid; bm_len = 1;
        end else if (tx_valid == bm_prev) begin
          bm_len++;
        end else begin
          if (!bm_first && bm_len != (bm_prev ? 16 : 4)) bm_viol++;
          if (!bm_first) bm_runs++;
          bm_first = 0; bm_prev = tx_valid; bm_len = 1;
        end
      end
    end
  end

  task automatic wr_ctl(input bit run, input bit lng, input bit cnt);
    @(posedge clk); #2;
    ctl_wr = 1'b1; ctl_run = run; ctl_long = lng; ctl_cont = cnt; flush = 1;
    @(posedge clk); #2;
    ctl_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic bit bit_at(input int n);
    return rec[n / 4][3 - (n % 4)];
  endfunction

  task automatic check_recurrence(input int len, input int tap, input string req);
    int bad = 0;
    for (int n = len; n < 4 * nrec; n++)
      if (bit_at(n) != (bit_at(n - len) ^ bit_at(n - tap))) bad++;
    check(bad == 0 && nrec > 100, req, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state
    check(pass == 0, "R1 pass", pass, 0);
    check(err_count == 0, "R1 err_count", err_count, 0);
    check(running == 0 && tx_valid == 0 && rx_ready == 0, "R1 idle", running, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check(running == 0 && tx_valid == 0, "R1 idle after release", tx_valid, 0);

    // 9-bit, continuous, stalled consumer
    stall_mode = 1;
    wr_ctl(1, 0, 1);
    check(running == 1 && rx_ready == 1, "R10 start runs", running, 1);
    cont_meas = 1;
    wait_cyc(1000);
    cont_meas = 0;
    check_recurrence(9, 5, "R2 9-bit recurrence");
    bad = 0;
    for (int k = 0; k + 511 < nrec; k++) if (rec[k] != rec[k + 511]) bad++;
    check(bad == 0 && nrec > 600, "R2 period 511", bad, 0);
    check(stall_viol == 0 && stall_seen > 100, "R4 stall hold", stall_viol, 0);
    check(cont_viol == 0, "R4 continuous valid", cont_viol, 0);
    check(pass == 1, "R7 pass 9-bit with loop delay", pass, 1);
    check(err_count == 0, "R6 no errors from latency", err_count, 0);

    // 15-bit, continuous
    stall_mode = 0;
    wr_ctl(1, 1, 1);
    wait_cyc(400);
    check_recurrence(15, 14, "R3 15-bit recurrence");
    check(pass == 1, "R7 pass 15-bit", pass, 1);
    check(err_count == 0, "R6 15-bit sync", err_count, 0);

    // burst mode
    wr_ctl(1, 0, 0);
    bm_init = 1; bm_en = 1;
    wait_cyc(300);
    bm_en = 0;
    check(bm_viol == 0 && bm_runs > 10, "R5 burst/gap lengths", bm_viol, 0);
    check(pass == 1 && err_count == 0, "R6 burst pass", err_count, 0);

    // single error
    wr_ctl(1, 0, 1);
    wait_cyc(40);
    check(pass == 1, "R7 pass before error", pass, 1);
    corrupt_left = 1;
    wait_cyc(20);
    check(err_count == 1, "R8 one miscompare counted", err_count, 1);
    check(pass == 0, "R8 pass falls", pass, 0);
    wait_cyc(60);
    check(pass == 0, "R8 fail latched", pass, 0);
    check(err_count == 1, "R8 no follow-on errors", err_count, 1);

    // stop
    wr_ctl(0, 0, 1);
    check(running == 0 && tx_valid == 0 && rx_ready == 0, "R10 stop", running, 0);
    check(err_count == 1, "R10 stop holds count", err_count, 1);
    force_rx = 1;
    wait_cyc(12);
    force_rx = 0;
    check(err_count == 1 && pass == 0, "R10 rx ignored when stopped", err_count, 1);

    // restart
    wr_ctl(1, 0, 1);
    check(err_count == 0, "R10 start zeroes count", err_count, 0);
    wait_cyc(30);
    check(pass == 1, "R10 restart clears latch", pass, 1);

    // saturation
    corrupt_left = 300;
    wait_cyc(400);
    check(err_count == 255, "R9 saturates", err_count, 255);
    check(pass == 0, "R8 pass low after many errors", pass, 0);

    wr_ctl(1, 1, 1);
    wait_cyc(40);
    check(pass == 1 && err_count == 0, "R10 recover after saturation", err_count, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule